// File: doc/BRIEF.md
# Tick-Compare Soft Interrupt Unit

This unit is a small bank of processor control registers that deals with software-raised and timer-raised interrupts. Its soft-interrupt register can be written in three ways. A plain write stores the value. A set-alias write ORs the data into the register. A clear-alias write removes the bits that are 1 in the data. A free-running system tick counter runs next to two compare registers, one for the supervisor and one for the hypervisor. Each compare register holds a target count and a disable flag in its top bit. When the counter reaches an enabled target, a fixed soft-interrupt bit is set (supervisor) or a one-bit hypervisor pending flag is set (hypervisor).

The unit also holds the processor interrupt level, a processor state word with an interrupt-enable bit, eight interrupt queue head/tail registers and a read-only version register. It produces a one-cycle recheck pulse whenever a write or a timer event could make a new interrupt deliverable. The logic that takes interrupts uses this pulse as its cue to arbitrate again. A write to the version register is dropped and produces a one-cycle illegal-access pulse.

All writes take effect on the clock edge at which `wr_en` is sampled high. The recheck and illegal pulses are registered and appear in the cycle that follows that edge. Reads are combinational from `rd_sel`.

Top module: `tick_softint_unit`

## Requirements
- R1: After a synchronous reset, the soft-interrupt register, the hypervisor pending flag, the interrupt level, the state word and the tick counter are zero. Both compare registers read back as 1 in bit 63 and 0 elsewhere. The recheck and illegal pulses are low.
- R2: A write to select 0 stores the low 17 bits of the write data into the soft-interrupt register. The higher bits are dropped.
- R3: A write to select 2 (clear alias) makes the soft-interrupt register equal to its old value AND the inverse of the write data. It raises no recheck pulse.
- R4: A write to select 1 (set alias) makes the soft-interrupt register equal to its old value OR the write data. A recheck pulse follows in the next cycle.
- R5: The tick counter (select 3, TICK_W bits) increases by one every cycle and wraps from all-ones to zero.
- R6: On an edge where the counter equals bits TICK_W-1:0 of the supervisor compare register (select 4) and bit 63 of that register is 0, bit 16 of the soft-interrupt register is set and a recheck pulse follows. When bit 63 is 1, neither happens.
- R7: On an edge where the counter equals the target of the hypervisor compare register (select 5) and bit 63 of that register is 0, the pending flag (select 6, bit 0) becomes 1 and a recheck pulse follows. A write to select 6 stores data bit 0.
- R8: A match fires only on equality. A target behind the counter fires only after the counter wraps around to it.
- R9: A write to the interrupt level (select 7, 4 bits) stores the value. It raises a recheck pulse only when the new value is lower than the current one.
- R10: A write to the state word (select 8, 12 bits) stores the value. It raises a recheck pulse only when bit 1 (interrupt enable) goes from 0 to 1.
- R11: Writes to the queue registers (selects 16 to 23) store the full 64-bit value and raise a recheck pulse.
- R12: The version register (select 9) always reads VERSION_VAL. A write to it changes no register and produces a one-cycle illegal pulse. No other write produces that pulse.
- R13: When a direct, set or clear write to the soft-interrupt register lands on the same edge as a supervisor match, the result is the written result with bit 16 ORed in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 5 | Register select for the write |
| wr_data | input | 64 | Write data |
| rd_sel | input | 5 | Register select for the read |
| rd_data | output | 64 | Combinational read data |
| softint_o | output | 17 | Soft-interrupt register contents |
| hpend_o | output | 1 | Hypervisor timer pending flag |
| recheck_o | output | 1 | One-cycle pulse: interrupts must be re-evaluated |
| illegal_o | output | 1 | One-cycle pulse: write to the read-only version register |

## Verification
The assertions check on every cycle the properties that tie one edge to the next. These are the set and clear alias arithmetic, the one-step counter advance, the match-to-bit-16 and match-to-pending links together with their recheck pulses, the recheck pulses from queue writes and from a lowered interrupt level, and the rule that the illegal pulse follows only a version write. Other behaviours show only in the bench scenarios: a target already passed waiting for the counter to wrap, a disabled compare staying silent, a write colliding with a match on one edge, the readback of every register, and the interrupt-enable 0-to-1 condition.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int DATA_W     = 64;
    localparam int SOFT_W     = 17;
    localparam int SMATCH_BIT = 16;
    localparam int PIL_W      = 4;
    localparam int PST_W      = 12;
    localparam int PST_IE_BIT = 1;
    localparam int NUM_Q      = 4;
    localparam int QREG_N     = 2 * NUM_Q;
    localparam int QIDX_W     = $clog2(QREG_N);
    localparam int ADDR_W     = 5;
    localparam int DIS_BIT    = DATA_W - 1;

    typedef enum logic [ADDR_W-1:0] {
        SEL_SOFT  = 5'd0,
        SEL_SET   = 5'd1,
        SEL_CLR   = 5'd2,
        SEL_TICK  = 5'd3,
        SEL_SCMP  = 5'd4,
        SEL_HCMP  = 5'd5,
        SEL_HPEND = 5'd6,
        SEL_PIL   = 5'd7,
        SEL_PST   = 5'd8,
        SEL_VER   = 5'd9,
        SEL_QBASE = 5'd16
    } reg_sel_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] sel;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    // compare register value that keeps the match silent
    localparam logic [DATA_W-1:0] CMP_RESET = {1'b1, {(DATA_W-1){1'b0}}};

    function automatic logic is_queue_sel(input logic [ADDR_W-1:0] sel);
        return (sel >= SEL_QBASE) && (sel < ADDR_W'(int'(SEL_QBASE) + QREG_N));
    endfunction

    function automatic logic [QIDX_W-1:0] queue_idx(input logic [ADDR_W-1:0] sel);
        logic [ADDR_W-1:0] off;
        off = sel - SEL_QBASE;
        return off[QIDX_W-1:0];
    endfunction

endpackage

// File: rtl/tsi_tick_counter.sv
module tsi_tick_counter #(
    parameter int TICK_W = 63
) (
    input  logic              clk,
    input  logic              rst,
    output logic [TICK_W-1:0] tick_o
);
    logic [TICK_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = cnt_q;
endmodule

// File: rtl/tsi_cmp_unit.sv
module tsi_cmp_unit
    import tsi_pkg::*;
#(
    parameter int TICK_W = 63
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TICK_W-1:0] tick,
    output logic [DATA_W-1:0] cmp_o,
    output logic              match_o
);
    logic [DATA_W-1:0] cmp_q;

    always_ff @(posedge clk) begin
        if (rst)         cmp_q <= CMP_RESET;
        else if (wr_hit) cmp_q <= wr_data;
    end

    // equality only: a target already passed waits for the wrap
    assign match_o = !cmp_q[DIS_BIT] && (cmp_q[TICK_W-1:0] == tick);
    assign cmp_o   = cmp_q;
endmodule

// File: rtl/tsi_irq_ctrl.sv
module tsi_irq_ctrl
    import tsi_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  wr_req_t                        req,
    input  logic                           smatch,
    input  logic                           hmatch,
    output logic [SOFT_W-1:0]              softint_o,
    output logic                           hpend_o,
    output logic [PIL_W-1:0]               pil_o,
    output logic [PST_W-1:0]               pst_o,
    output logic [QREG_N-1:0][DATA_W-1:0]  q_o,
    output logic                           recheck_o,
    output logic                           illegal_o
);
    logic [SOFT_W-1:0] soft_q, soft_base, soft_d;
    logic              hpend_q, hpend_d;
    logic [PIL_W-1:0]  pil_q;
    logic [PST_W-1:0]  pst_q;
    logic              recheck_q, illegal_q;
    logic              set_hit, pil_drop, ie_rise, q_hit, ver_hit;
    logic [QREG_N-1:0] q_wr;

    always_comb begin
        soft_base = soft_q;
        if (req.en) begin
            case (req.sel)
                SEL_SOFT: soft_base = req.data[SOFT_W-1:0];
                SEL_SET:  soft_base = soft_q | req.data[SOFT_W-1:0];
                SEL_CLR:  soft_base = soft_q & ~req.data[SOFT_W-1:0];
                default:  soft_base = soft_q;
            endcase
        end
        soft_d = soft_base;
        if (smatch) soft_d[SMATCH_BIT] = 1'b1;
    end

    always_comb begin
        hpend_d = hpend_q;
        if (req.en && req.sel == SEL_HPEND) hpend_d = req.data[0];
        if (hmatch) hpend_d = 1'b1;
    end

    assign set_hit  = req.en && (req.sel == SEL_SET);
    assign pil_drop = req.en && (req.sel == SEL_PIL) && (req.data[PIL_W-1:0] < pil_q);
    assign ie_rise  = req.en && (req.sel == SEL_PST) && req.data[PST_IE_BIT] && !pst_q[PST_IE_BIT];
    assign q_hit    = req.en && is_queue_sel(req.sel);
    assign ver_hit  = req.en && (req.sel == SEL_VER);

    always_ff @(posedge clk) begin
        if (rst) begin
            soft_q    <= '0;
            hpend_q   <= 1'b0;
            pil_q     <= '0;
            pst_q     <= '0;
            recheck_q <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            soft_q    <= soft_d;
            hpend_q   <= hpend_d;
            if (req.en && req.sel == SEL_PIL) pil_q <= req.data[PIL_W-1:0];
            if (req.en && req.sel == SEL_PST) pst_q <= req.data[PST_W-1:0];
            recheck_q <= set_hit | pil_drop | ie_rise | q_hit | smatch | hmatch;
            illegal_q <= ver_hit;
        end
    end

    for (genvar i = 0; i < QREG_N; i++) begin : g_queue
        logic [DATA_W-1:0] qreg_q;
        assign q_wr[i] = q_hit && (queue_idx(req.sel) == QIDX_W'(i));
        always_ff @(posedge clk) begin
            if (rst)          qreg_q <= '0;
            else if (q_wr[i]) qreg_q <= req.data;
        end
        assign q_o[i] = qreg_q;
    end

    assign softint_o = soft_q;
    assign hpend_o   = hpend_q;
    assign pil_o     = pil_q;
    assign pst_o     = pst_q;
    assign recheck_o = recheck_q;
    assign illegal_o = illegal_q;
endmodule

// File: rtl/tick_softint_unit.sv
module tick_softint_unit
    import tsi_pkg::*;
#(
    parameter int                TICK_W      = 63,
    parameter logic [DATA_W-1:0] VERSION_VAL = 64'h0000_0017_0002_0001
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_sel,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_sel,
    output logic [DATA_W-1:0]    rd_data,
    output logic [SOFT_W-1:0]    softint_o,
    output logic                 hpend_o,
    output logic                 recheck_o,
    output logic                 illegal_o
);
    wr_req_t                       req;
    logic [TICK_W-1:0]             tick_w;
    logic [DATA_W-1:0]             scmp_w, hcmp_w;
    logic                          smatch_w, hmatch_w;
    logic [PIL_W-1:0]              pil_w;
    logic [PST_W-1:0]              pst_w;
    logic [QREG_N-1:0][DATA_W-1:0] q_w;

    assign req = '{en: wr_en, sel: wr_sel, data: wr_data};

    tsi_tick_counter #(.TICK_W(TICK_W)) u_tick (
        .clk(clk), .rst(rst), .tick_o(tick_w)
    );

    tsi_cmp_unit #(.TICK_W(TICK_W)) u_scmp (
        .clk(clk), .rst(rst),
        .wr_hit(wr_en && wr_sel == SEL_SCMP), .wr_data(wr_data),
        .tick(tick_w), .cmp_o(scmp_w), .match_o(smatch_w)
    );

    tsi_cmp_unit #(.TICK_W(TICK_W)) u_hcmp (
        .clk(clk), .rst(rst),
        .wr_hit(wr_en && wr_sel == SEL_HCMP), .wr_data(wr_data),
        .tick(tick_w), .cmp_o(hcmp_w), .match_o(hmatch_w)
    );

    tsi_irq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .req(req),
        .smatch(smatch_w), .hmatch(hmatch_w),
        .softint_o(softint_o), .hpend_o(hpend_o),
        .pil_o(pil_w), .pst_o(pst_w), .q_o(q_w),
        .recheck_o(recheck_o), .illegal_o(illegal_o)
    );

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_SOFT, SEL_SET, SEL_CLR: rd_data = DATA_W'(softint_o);
            SEL_TICK:  rd_data = DATA_W'(tick_w);
            SEL_SCMP:  rd_data = scmp_w;
            SEL_HCMP:  rd_data = hcmp_w;
            SEL_HPEND: rd_data = DATA_W'(hpend_o);
            SEL_PIL:   rd_data = DATA_W'(pil_w);
            SEL_PST:   rd_data = DATA_W'(pst_w);
            SEL_VER:   rd_data = VERSION_VAL;
            default:   if (is_queue_sel(rd_sel)) rd_data = q_w[queue_idx(rd_sel)];
        endcase
    end
endmodule

// File: rtl/tsi_checker.sv
module tsi_checker
    import tsi_pkg::*;
#(
    parameter int TICK_W = 63
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic [SOFT_W-1:0] softint_o,
    input logic              hpend_o,
    input logic              recheck_o,
    input logic              illegal_o,
    input logic [TICK_W-1:0] tick,
    input logic [DATA_W-1:0] scmp,
    input logic [DATA_W-1:0] hcmp,
    input logic [PIL_W-1:0]  pil
);
    localparam logic [SOFT_W-1:0] MBIT = SOFT_W'(1) << SMATCH_BIT;

    assert_set_alias_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_SET) |=> recheck_o
            && ((softint_o & $past(wr_data[SOFT_W-1:0])) == $past(wr_data[SOFT_W-1:0]))
            && ((softint_o & $past(softint_o)) == $past(softint_o)));

    assert_clear_alias_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_CLR) |=>
            ((softint_o & $past(wr_data[SOFT_W-1:0]) & ~MBIT) == '0));

    assert_tick_step_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> tick == $past(tick) + 1'b1);

    assert_smatch_R6: assert property (@(posedge clk) disable iff (rst)
        (!scmp[DATA_W-1] && scmp[TICK_W-1:0] == tick) |=> softint_o[SMATCH_BIT] && recheck_o);

    assert_hmatch_R7: assert property (@(posedge clk) disable iff (rst)
        (!hcmp[DATA_W-1] && hcmp[TICK_W-1:0] == tick) |=> hpend_o && recheck_o);

    assert_pil_recheck_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_PIL && wr_data[PIL_W-1:0] < pil) |=> recheck_o);

    assert_queue_recheck_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel >= SEL_QBASE && wr_sel < ADDR_W'(int'(SEL_QBASE) + QREG_N)) |=> recheck_o);

    assert_version_err_R12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_VER) |=> illegal_o);

    assert_no_spurious_err_R12: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_sel == SEL_VER) |=> !illegal_o);
endmodule

bind tick_softint_unit tsi_checker #(.TICK_W(TICK_W)) u_tsi_checker (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .softint_o(softint_o), .hpend_o(hpend_o), .recheck_o(recheck_o),
    .illegal_o(illegal_o), .tick(tick_w), .scmp(scmp_w), .hcmp(hcmp_w), .pil(pil_w)
);

// File: tb/tick_softint_unit_tb_top.sv
module tick_softint_unit_tb_top;
    import tsi_pkg::*;

    localparam int          TW   = 10;
    localparam int          TMOD = 1 << TW;
    localparam logic [63:0] VER  = 64'h0000_00A5_0000_0C3E;
    localparam logic [63:0] DIS  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] SMSK = 64'h1_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_sel = '0;
    logic [63:0] wr_data = '0;
    logic [4:0]  rd_sel = '0;
    logic [63:0] rd_data;
    logic [16:0] softint_o;
    logic        hpend_o, recheck_o, illegal_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tick_softint_unit #(.TICK_W(TW), .VERSION_VAL(VER)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .softint_o(softint_o),
        .hpend_o(hpend_o), .recheck_o(recheck_o), .illegal_o(illegal_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] sel, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] sel, output logic [63:0] v);
        rd_sel = sel;
        #1 v = rd_data;
    endtask

    function automatic logic [63:0] tmod(input longint v);
        return 64'((v % TMOD + TMOD) % TMOD);
    endfunction

    initial begin
        repeat (300000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] v, x, y, t, o, d;
        int n;
        bit seen, rc;

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1: reset state, one edge after release
        chk(softint_o == 0, "R1 softint", 64'(softint_o), 0);
        chk(hpend_o == 0, "R1 hpend", 64'(hpend_o), 0);
        chk(recheck_o == 0 && illegal_o == 0, "R1 pulses", {recheck_o, illegal_o}, 0);
        rd(SEL_TICK, v);  chk(v == 1, "R1 tick", v, 1);
        rd(SEL_SCMP, v);  chk(v == DIS, "R1 scmp", v, DIS);
        rd(SEL_HCMP, v);  chk(v == DIS, "R1 hcmp", v, DIS);
        rd(SEL_PIL, v);   chk(v == 0, "R1 pil", v, 0);
        rd(SEL_PST, v);   chk(v == 0, "R1 pstate", v, 0);

        // R2: direct write sweep
        for (int i = 0; i < 17; i++) begin
            wr(SEL_SOFT, 64'd1 << i);
            chk(64'(softint_o) == (64'd1 << i), "R2 single bit", 64'(softint_o), 64'd1 << i);
        end
        wr(SEL_SOFT, '1);
        chk(64'(softint_o) == SMSK, "R2 width", 64'(softint_o), SMSK);

        // R3 / R4: alias arithmetic sweep
        for (int k = 0; k < 16; k++) begin
            o = (64'(k) * 64'h1357) & SMSK;
            d = (64'(k) * 64'h0BAD + 7) & SMSK;
            wr(SEL_SOFT, o);
            wr(SEL_SET, d);
            chk(64'(softint_o) == (o | d), "R4 set alias", 64'(softint_o), o | d);
            chk(recheck_o == 1, "R4 set recheck", 64'(recheck_o), 1);
            wr(SEL_SOFT, o);
            wr(SEL_CLR, d);
            chk(64'(softint_o) == (o & ~d & SMSK), "R3 clear alias", 64'(softint_o), o & ~d & SMSK);
            chk(recheck_o == 0, "R3 no recheck", 64'(recheck_o), 0);
        end
        wr(SEL_SOFT, 0);

        // R5: step and wrap
        @(negedge clk); rd(SEL_TICK, x);
        repeat (7) @(negedge clk);
        rd(SEL_TICK, y);
        chk(y == tmod(longint'(x) + 7), "R5 step", y, tmod(longint'(x) + 7));
        n = 0;
        while (y != TMOD - 1 && n < 2 * TMOD) begin @(negedge clk); rd(SEL_TICK, y); n++; end
        @(negedge clk); rd(SEL_TICK, y);
        chk(y == 0, "R5 wrap", y, 0);

        // R6: supervisor match
        rd(SEL_TICK, x); t = tmod(longint'(x) + 20);
        wr(SEL_SCMP, t);
        chk(softint_o[16] == 0, "R6 before match", 64'(softint_o), 0);
        seen = 0; n = 0;
        while (!seen && n < 100) begin @(negedge clk); n++; seen = softint_o[16]; end
        rd(SEL_TICK, y);
        chk(seen && y == tmod(longint'(t) + 1), "R6 match time", y, tmod(longint'(t) + 1));
        chk(recheck_o == 1, "R6 match recheck", 64'(recheck_o), 1);
        wr(SEL_SCMP, DIS); wr(SEL_SOFT, 0);
        // R6: disabled compare stays silent
        rd(SEL_TICK, x);
        wr(SEL_SCMP, DIS | tmod(longint'(x) + 10));
        rc = 0;
        repeat (30) begin @(negedge clk); rc |= recheck_o | softint_o[16]; end
        chk(rc == 0, "R6 disabled", 64'(rc), 0);
        wr(SEL_SCMP, DIS);

        // R7: hypervisor match and pending write
        rd(SEL_TICK, x); t = tmod(longint'(x) + 20);
        wr(SEL_HCMP, t);
        chk(hpend_o == 0, "R7 before match", 64'(hpend_o), 0);
        seen = 0; n = 0;
        while (!seen && n < 100) begin @(negedge clk); n++; seen = hpend_o; end
        rd(SEL_TICK, y);
        chk(seen && y == tmod(longint'(t) + 1), "R7 match time", y, tmod(longint'(t) + 1));
        chk(recheck_o == 1 && softint_o == 0, "R7 recheck only hpend", {recheck_o, 46'd0, softint_o}, 64'd1 << 63);
        wr(SEL_HCMP, DIS);
        wr(SEL_HPEND, 0);
        chk(hpend_o == 0, "R7 pending clear", 64'(hpend_o), 0);

        // R8: target behind the counter waits for the wrap
        rd(SEL_TICK, x); t = tmod(longint'(x) - 5);
        wr(SEL_SCMP, t);
        seen = 0;
        repeat (600) begin @(negedge clk); seen |= softint_o[16]; end
        chk(seen == 0, "R8 no early fire", 64'(seen), 0);
        n = 0;
        while (!seen && n < TMOD) begin @(negedge clk); n++; seen = softint_o[16]; end
        rd(SEL_TICK, y);
        chk(seen && y == tmod(longint'(t) + 1), "R8 fires after wrap", y, tmod(longint'(t) + 1));
        wr(SEL_SCMP, DIS); wr(SEL_SOFT, 0);

        // R13: direct write meets match on one edge
        rd(SEL_TICK, x); t = tmod(longint'(x) + 20);
        wr(SEL_SCMP, t);
        n = 0; rd(SEL_TICK, y);
        while (y != t && n < 100) begin @(negedge clk); rd(SEL_TICK, y); n++; end
        wr_en = 1'b1; wr_sel = SEL_SOFT; wr_data = 64'h5;
        @(negedge clk); wr_en = 1'b0;
        chk(64'(softint_o) == 64'h10005, "R13 merge", 64'(softint_o), 64'h10005);
        wr(SEL_SCMP, DIS); wr(SEL_SOFT, 0);

        // R9: interrupt level
        wr(SEL_PIL, 8); chk(recheck_o == 0, "R9 raise", 64'(recheck_o), 0);
        wr(SEL_PIL, 3); chk(recheck_o == 1, "R9 lower", 64'(recheck_o), 1);
        wr(SEL_PIL, 3); chk(recheck_o == 0, "R9 equal", 64'(recheck_o), 0);
        wr(SEL_PIL, 5); chk(recheck_o == 0, "R9 raise again", 64'(recheck_o), 0);
        rd(SEL_PIL, v); chk(v == 5, "R9 readback", v, 5);

        // R10: state word interrupt enable
        wr(SEL_PST, 0);      chk(recheck_o == 0, "R10 stay 0", 64'(recheck_o), 0);
        wr(SEL_PST, 2);      chk(recheck_o == 1, "R10 rise", 64'(recheck_o), 1);
        wr(SEL_PST, 2);      chk(recheck_o == 0, "R10 stay 1", 64'(recheck_o), 0);
        wr(SEL_PST, 0);
        wr(SEL_PST, 12'hFFD); chk(recheck_o == 0, "R10 other bits", 64'(recheck_o), 0);
        rd(SEL_PST, v);      chk(v == 64'hFFD, "R10 readback", v, 64'hFFD);

        // R11: queue registers
        for (int q = 0; q < 8; q++) begin
            d = 64'hC0DE_0000_0000_0000 | (64'(q) * 64'h1111_1111);
            wr(5'(16 + q), d);
            chk(recheck_o == 1, "R11 recheck", 64'(recheck_o), 1);
        end
        for (int q = 0; q < 8; q++) begin
            d = 64'hC0DE_0000_0000_0000 | (64'(q) * 64'h1111_1111);
            rd(5'(16 + q), v);
            chk(v == d, "R11 readback", v, d);
        end

        // R12: read-only version
        rd(SEL_VER, v); chk(v == VER, "R12 read", v, VER);
        wr(SEL_VER, 64'h1234);
        chk(illegal_o == 1 && recheck_o == 0, "R12 illegal pulse", {illegal_o, recheck_o}, 64'h2);
        rd(SEL_VER, v); chk(v == VER, "R12 unchanged", v, VER);
        @(negedge clk);
        chk(illegal_o == 0, "R12 one cycle", 64'(illegal_o), 0);
        wr(SEL_SOFT, 1);
        chk(illegal_o == 0, "R12 other write", 64'(illegal_o), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule